// File: doc/BRIEF.md
# Redundant Store Pair Checker

This block sits at the commit end of a core that runs one program as two redundant threads. Every store committed by the leading thread is parked in an in-order buffer. It stays there until the trailing thread commits its own copy of the same store. The trailing copy is checked against the oldest parked store. If both the address and the data agree, the store is written to memory through a valid/ready port. If they differ, no write takes place and the block enters a permanent fault state.

Because each store waits for its redundant twin, entries stay in the buffer much longer than they would in an ordinary store queue. When the buffer is full, only the leading thread's enqueue port is held off. The trailing commit port does not depend on how full the buffer is, so the store that would free an entry can always be checked.

The control is a three-state machine:

- WAIT accepts a trailing store.
- ISSUE presents one memory write and holds it until the memory accepts it.
- FAULT is entered on a mismatch or on a trailing store with nothing to match, and it is left only by reset.

Transitions:

- WAIT to ISSUE on a matching trailing store.
- WAIT to FAULT on a mismatching or orphan trailing store.
- ISSUE to WAIT on the memory handshake.
- FAULT to FAULT in every other case.

Top module: `store_pair_checker`

## Requirements
- R1: After reset, empty=1, full=0, fault=0, mem_valid=0, lead_ready=1 and trail_ready=1.
- R2: A leading store is taken on a clock edge where lead_valid and lead_ready are both high. empty goes low after that edge, and no memory write is raised by leading stores alone.
- R3: A trailing store whose address and data both equal the oldest pending leading store raises mem_valid after its accepting edge, with mem_addr and mem_data equal to that store.
- R4: While mem_valid is high and mem_ready is low, mem_valid, mem_addr and mem_data hold steady. The entry retires on the handshake edge, and exactly one write is made per matched pair.
- R5: trail_ready is low while a memory write is pending.
- R6: Trailing stores are matched in order against leading stores, oldest first.
- R7: A trailing store whose address differs from the oldest pending store sets fault after its accepting edge, and no write is issued.
- R8: A trailing store whose data differs from the oldest pending store sets fault after its accepting edge, and no write is issued.
- R9: fault stays set until reset. While it is set, mem_valid and trail_ready stay low, including after further leading stores.
- R10: A trailing store that arrives while the buffer is empty sets fault.
- R11: After DEPTH leading stores with none retired, full=1 and lead_ready=0, and an offered leading store is dropped. trail_ready stays high while the buffer is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lead_valid | input | 1 | Leading-thread store offered |
| lead_ready | output | 1 | Buffer can take a leading store |
| lead_addr | input | ADDR_W | Leading store address |
| lead_data | input | DATA_W | Leading store data |
| trail_valid | input | 1 | Trailing-thread store committing |
| trail_ready | output | 1 | Checker can take a trailing store |
| trail_addr | input | ADDR_W | Trailing store address |
| trail_data | input | DATA_W | Trailing store data |
| mem_valid | output | 1 | Verified store write to memory |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Write address |
| mem_data | output | DATA_W | Write data |
| fault | output | 1 | Sticky redundancy fault |
| full | output | 1 | Buffer holds DEPTH stores |
| empty | output | 1 | Buffer holds no store |

## Verification
The status outputs (empty, full, lead_ready) change one edge after a leading store is taken or an entry retires. mem_valid, fault and trail_ready change one edge after a trailing store is accepted, and mem_valid drops one edge after the memory handshake. The bench drives every input on the falling clock edge. It reads the outputs on the next falling edge, which falls after exactly one rising edge has acted on the stimulus. For pending writes it holds mem_ready low over several cycles and checks that the write stays unchanged before completing the handshake.

// File: rtl/spc_pkg.sv
package spc_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_FAULT = 2'd2
    } rel_state_e;

endpackage

// File: rtl/spc_store_fifo.sv
module spc_store_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    logic [W-1:0]  slots [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign rdata = slots[rd_ptr];
    assign full  = (count == CAP);
    assign empty = (count == '0);

endmodule

// File: rtl/spc_pair_cmp.sv
module spc_pair_cmp #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic [DATA_W-1:0] ref_data,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic [DATA_W-1:0] chk_data,
    output logic              pair_eq
);
    logic addr_eq;
    logic data_eq;

    assign addr_eq = (ref_addr == chk_addr);
    assign data_eq = (ref_data == chk_data);
    assign pair_eq = addr_eq & data_eq;

endmodule

// File: rtl/spc_release_ctrl.sv
module spc_release_ctrl
    import spc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trail_valid,
    input  logic have_entry,
    input  logic pair_eq,
    input  logic mem_ready,
    output logic trail_ready,
    output logic mem_valid,
    output logic retire,
    output logic fault
);
    rel_state_e state;
    rel_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_WAIT;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT: begin
                if (trail_valid) begin
                    state_nx = (have_entry && pair_eq) ? ST_ISSUE : ST_FAULT;
                end
            end
            ST_ISSUE: begin
                if (mem_ready) begin
                    state_nx = ST_WAIT;
                end
            end
            ST_FAULT: state_nx = ST_FAULT;
            default:  state_nx = ST_FAULT;
        endcase
    end

    always_comb begin
        trail_ready = 1'b0;
        mem_valid   = 1'b0;
        fault       = 1'b0;
        unique case (state)
            ST_WAIT:  trail_ready = 1'b1;
            ST_ISSUE: mem_valid   = 1'b1;
            ST_FAULT: fault       = 1'b1;
            default:  fault       = 1'b1;
        endcase
        retire = mem_valid & mem_ready;
    end

endmodule

// File: rtl/store_pair_checker.sv
module store_pair_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lead_valid,
    output logic              lead_ready,
    input  logic [ADDR_W-1:0] lead_addr,
    input  logic [DATA_W-1:0] lead_data,
    input  logic              trail_valid,
    output logic              trail_ready,
    input  logic [ADDR_W-1:0] trail_addr,
    input  logic [DATA_W-1:0] trail_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              fault,
    output logic              full,
    output logic              empty
);
    localparam int ENTRY_W = ADDR_W + DATA_W;

    logic               push;
    logic               retire;
    logic               pair_eq;
    logic [ENTRY_W-1:0] head;
    logic [ADDR_W-1:0]  head_addr;
    logic [DATA_W-1:0]  head_data;

    assign lead_ready = ~full;
    assign push       = lead_valid & lead_ready;

    spc_store_fifo #(
        .W     (ENTRY_W),
        .DEPTH (DEPTH)
    ) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata ({lead_addr, lead_data}),
        .pop   (retire),
        .rdata (head),
        .full  (full),
        .empty (empty)
    );

    assign head_addr = head[ENTRY_W-1:DATA_W];
    assign head_data = head[DATA_W-1:0];

    spc_pair_cmp #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_cmp (
        .ref_addr (head_addr),
        .ref_data (head_data),
        .chk_addr (trail_addr),
        .chk_data (trail_data),
        .pair_eq  (pair_eq)
    );

    spc_release_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .trail_valid (trail_valid),
        .have_entry  (~empty),
        .pair_eq     (pair_eq),
        .mem_ready   (mem_ready),
        .trail_ready (trail_ready),
        .mem_valid   (mem_valid),
        .retire      (retire),
        .fault       (fault)
    );

    assign mem_addr = head_addr;
    assign mem_data = head_data;

endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lead_ready,
    input logic              trail_valid,
    input logic              trail_ready,
    input logic [ADDR_W-1:0] trail_addr,
    input logic [DATA_W-1:0] trail_data,
    input logic [ADDR_W-1:0] head_addr,
    input logic [DATA_W-1:0] head_data,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_data,
    input logic              fault,
    input logic              full,
    input logic              empty
);
    logic trail_fire;
    assign trail_fire = trail_valid & trail_ready;

    AST_MATCH_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        (trail_fire && !empty && trail_addr == head_addr && trail_data == head_data)
        |=> (mem_valid && mem_addr == $past(trail_addr) && mem_data == $past(trail_data))); // R3

    AST_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data))); // R4

    AST_TRAIL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !trail_ready); // R5

    AST_MISMATCH_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (trail_fire && !empty && (trail_addr != head_addr || trail_data != head_data))
        |=> (fault && !mem_valid)); // R7

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault); // R9

    AST_NO_WRITE_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!mem_valid && !trail_ready)); // R9

    AST_ORPHAN_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (trail_fire && empty) |=> fault); // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !lead_ready); // R11

endmodule

bind store_pair_checker spc_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_spc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .lead_ready  (lead_ready),
    .trail_valid (trail_valid),
    .trail_ready (trail_ready),
    .trail_addr  (trail_addr),
    .trail_data  (trail_data),
    .head_addr   (head_addr),
    .head_data   (head_data),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_addr    (mem_addr),
    .mem_data    (mem_data),
    .fault       (fault),
    .full        (full),
    .empty       (empty)
);

// File: tb/tb_store_pair_checker.sv
module tb_store_pair_checker;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int DEPTH = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lead_valid = 1'b0;
    logic          lead_ready;
    logic [AW-1:0] lead_addr = '0;
    logic [DW-1:0] lead_data = '0;
    logic          trail_valid = 1'b0;
    logic          trail_ready;
    logic [AW-1:0] trail_addr = '0;
    logic [DW-1:0] trail_data = '0;
    logic          mem_valid;
    logic          mem_ready = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;
    logic          fault;
    logic          full;
    logic          empty;

    int tests = 0;
    int fails = 0;
    int writes = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    store_pair_checker #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n),
        .lead_valid(lead_valid), .lead_ready(lead_ready),
        .lead_addr(lead_addr), .lead_data(lead_data),
        .trail_valid(trail_valid), .trail_ready(trail_ready),
        .trail_addr(trail_addr), .trail_data(trail_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data),
        .fault(fault), .full(full), .empty(empty)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst_n && mem_valid && mem_ready) writes <= writes + 1;
    end

    initial begin
        wait (cycles > 100000);
        fails++;
        $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 100000)", cycles);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; lead_valid = 1'b0; trail_valid = 1'b0; mem_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic push_lead(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        lead_valid = 1'b1; lead_addr = a; lead_data = d;
        @(negedge clk);
        lead_valid = 1'b0;
    endtask

    task automatic send_trail(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        trail_valid = 1'b1; trail_addr = a; trail_data = d;
        @(negedge clk);
        trail_valid = 1'b0;
    endtask

    task automatic mem_accept();
        @(negedge clk);
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "empty", empty, 1);
        chk("R1", "full", full, 0);
        chk("R1", "fault", fault, 0);
        chk("R1", "mem_valid", mem_valid, 0);
        chk("R1", "lead_ready", lead_ready, 1);
        chk("R1", "trail_ready", trail_ready, 1);
    endtask

    task automatic t_single();
        int w0;
        do_reset();
        w0 = writes;
        push_lead(32'h0000_4000, 32'hCAFE_0001);
        chk("R2", "empty after push", empty, 0);
        chk("R2", "no write from lead alone", mem_valid, 0);
        send_trail(32'h0000_4000, 32'hCAFE_0001);
        chk("R3", "mem_valid", mem_valid, 1);
        chk("R3", "mem_addr", mem_addr, 32'h0000_4000);
        chk("R3", "mem_data", mem_data, 32'hCAFE_0001);
        chk("R5", "trail_ready while pending", trail_ready, 0);
        repeat (3) @(negedge clk);
        chk("R4", "mem_valid held", mem_valid, 1);
        chk("R4", "mem_addr held", mem_addr, 32'h0000_4000);
        chk("R4", "mem_data held", mem_data, 32'hCAFE_0001);
        mem_accept();
        chk("R4", "mem_valid after handshake", mem_valid, 0);
        chk("R4", "empty after retire", empty, 1);
        chk("R4", "write count", writes - w0, 1);
        chk("R5", "trail_ready after retire", trail_ready, 1);
    endtask

    task automatic t_order();
        do_reset();
        for (int i = 0; i < 3; i++) push_lead(32'h100 + i * 8, 32'h5000 + i);
        for (int i = 0; i < 3; i++) begin
            send_trail(32'h100 + i * 8, 32'h5000 + i);
            chk("R6", "mem_addr oldest first", mem_addr, 32'h100 + i * 8);
            chk("R6", "mem_data oldest first", mem_data, 32'h5000 + i);
            mem_accept();
        end
        chk("R6", "empty after in-order drain", empty, 1);
        chk("R6", "fault", fault, 0);
    endtask

    task automatic t_fill();
        int w0;
        do_reset();
        w0 = writes;
        for (int i = 0; i < DEPTH; i++) push_lead(32'h2000 + i * 4, 32'hA5A5_0000 ^ i);
        chk("R11", "full", full, 1);
        chk("R11", "lead_ready when full", lead_ready, 0);
        chk("R11", "trail_ready when full", trail_ready, 1);
        @(negedge clk);
        lead_valid = 1'b1; lead_addr = 32'hDEAD_0000; lead_data = 32'hDEAD_0001;
        @(negedge clk);
        lead_valid = 1'b0;
        chk("R11", "still full after dropped push", full, 1);
        for (int i = 0; i < DEPTH; i++) begin
            send_trail(32'h2000 + i * 4, 32'hA5A5_0000 ^ i);
            if (i == 0) chk("R11", "trail accepted while full", mem_valid, 1);
            chk("R6", "drain addr", mem_addr, 32'h2000 + i * 4);
            mem_accept();
        end
        chk("R11", "empty after draining DEPTH (extra push dropped)", empty, 1);
        chk("R11", "writes", writes - w0, DEPTH);
        chk("R11", "fault", fault, 0);
    endtask

    task automatic t_mismatch(input bit bad_addr);
        int w0;
        string req;
        req = bad_addr ? "R7" : "R8";
        do_reset();
        w0 = writes;
        push_lead(32'h0000_8000, 32'h1234_5678);
        if (bad_addr) send_trail(32'h0000_8004, 32'h1234_5678);
        else          send_trail(32'h0000_8000, 32'h1234_5679);
        chk(req, "fault", fault, 1);
        chk(req, "mem_valid", mem_valid, 0);
        push_lead(32'h0000_9000, 32'h1);
        mem_ready = 1'b1;
        repeat (4) @(negedge clk);
        mem_ready = 1'b0;
        chk("R9", "fault sticky", fault, 1);
        chk("R9", "mem_valid in fault", mem_valid, 0);
        chk("R9", "trail_ready in fault", trail_ready, 0);
        chk("R9", "no writes", writes - w0, 0);
    endtask

    task automatic t_orphan();
        do_reset();
        send_trail(32'h0000_0040, 32'h7);
        chk("R10", "fault on orphan", fault, 1);
        chk("R10", "mem_valid on orphan", mem_valid, 0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_order();
        t_fill();
        t_mismatch(1'b1);
        t_mismatch(1'b0);
        t_orphan();
        t_reset();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule